// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block brings a stereo converter out of power-down in an orderly way. After reset it keeps the converter powered down and its voltage reference off. It leaves that state only when its clocks are valid. In master mode a running master clock is enough. In slave mode the master clock must also stand in a supported ratio to the frame clock. The sequencer measures that ratio by counting master-clock ticks across each frame period.

Once the clocks qualify, the sequencer enables the reference and waits a fixed number of frame periods. It then takes one of two paths, chosen by the high-pass-defeat input:

- **Filter settling.** With the high-pass filter in use, it waits a long settling interval.
- **DC calibration.** With the filter defeated, it first detaches the converter inputs from the pins for one frame. It then ties them to a common reference for a calibration interval, and finally reconnects them.

Ready is raised at the end of either path. If the master clock stops for longer than a timeout, the block drops back to power-down.

Both clocks arrive as single-cycle tick strobes that are already synchronous to the system clock `clk`.

Top module: `conv_init_seq`

## Requirements
- R1: While reset is held, and until the clocks qualify, the outputs are: `pdn`=1, and `ref_en`, `in_disc`, `cal_short`, `ready`, `oclk_en` all 0, with `ratio_code`=0.
- R2: In master mode (`master_mode`=1), `pdn` falls within a few cycles of master-clock ticks appearing. No frame ticks are needed for this.
- R3: In slave mode, `pdn` falls only after two consecutive complete frame periods have measured the same supported ratio. The supported ratios are 256, 384 and 512. `ratio_code` then reads 1, 2 or 3 respectively. Any other count, or two differing counts, keeps `pdn` high and `ratio_code` at 0.
- R4: A frame period's measurement is the number of master ticks after one frame tick, up to and including the next frame tick. The first frame tick after clocks start only opens a measurement. In slave mode, therefore, `pdn` falls after the third frame tick.
- R5: When `pdn` falls, `ref_en` rises. Exactly REF_FRAMES frame ticks then pass with the inputs connected before either path starts.
- R6: If `hp_defeat` is 0 when the reference wait ends, SETTLE_FRAMES more frame ticks pass before `ready` rises. `ready` stays high until power-down.
- R7: If `hp_defeat` is 1 when the reference wait ends, the following happens in order:
  - `in_disc` alone is high for one frame tick.
  - `in_disc` and `cal_short` are both high for CAL_FRAMES frame ticks.
  - Both fall and `ready` rises.
- R8: While `ready` is high, `ref_en` is high and `in_disc` and `cal_short` are low.
- R9: If the master clock stops for TIMEOUT system cycles, the block returns to power-down with the R1 output values. A shorter gap has no effect.
- R10: `oclk_en` is high only in master mode outside power-down. In slave mode it stays 0.
- R11: `hp_defeat` is looked at only when the reference wait ends. A change during settling does not alter the path taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master mode, 0 = slave mode |
| hp_defeat | input | 1 | 1 = high-pass filter defeated, which selects DC calibration |
| mclk_tick | input | 1 | One-cycle strobe per master-clock edge |
| frame_tick | input | 1 | One-cycle strobe per frame-clock period |
| pdn | output | 1 | Converter held in power-down |
| ref_en | output | 1 | Voltage reference enabled |
| in_disc | output | 1 | Converter inputs detached from pins |
| cal_short | output | 1 | Converter inputs tied to the common reference |
| ready | output | 1 | Initialization complete |
| oclk_en | output | 1 | Output clock generation enabled |
| ratio_code | output | 2 | Locked clock ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |

## Verification
The hardest states to reach from the ports are the slave-mode rejections. Two good measurements of different ratios must never lock. The half-measured frame that follows clock start must never count toward the pair. The stimulus reaches these states with a tick generator whose frame length can alternate between 256 and 384 on every period, or sit at an unsupported 300. The bench also counts the frame ticks seen while still powered down, so a lock that comes one frame early or late shows up. The hp-defeat sampling point is reached by flipping the input partway through settling.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;

  typedef enum logic [2:0] {
    ST_PDN    = 3'd0,
    ST_REF    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_ISO    = 3'd3,
    ST_CAL    = 3'd4,
    ST_RDY    = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    RAT_NONE = 2'd0,
    RAT_LOW  = 2'd1,
    RAT_MID  = 2'd2,
    RAT_HIGH = 2'd3
  } ratio_code_t;

endpackage

// File: rtl/cis_mclk_watch.sv
module cis_mclk_watch #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_tick,
  output logic mclk_ok
);
  localparam int IW = $clog2(TIMEOUT + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(TIMEOUT);

  logic [IW-1:0] idle_q, idle_d;

  always_comb begin
    if (mclk_tick)              idle_d = '0;
    else if (idle_q == IDLE_MAX) idle_d = idle_q;
    else                        idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= IDLE_MAX;
    else        idle_q <= idle_d;
  end

  assign mclk_ok = (idle_q != IDLE_MAX);
endmodule

// File: rtl/cis_ratio_meter.sv
module cis_ratio_meter
  import conv_init_pkg::*;
#(
  parameter int RATIO_LOW  = 256,
  parameter int RATIO_MID  = 384,
  parameter int RATIO_HIGH = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mclk_ok,
  input  logic        mclk_tick,
  input  logic        frame_tick,
  output logic        lock,
  output ratio_code_t code
);
  localparam int CW = $clog2(RATIO_HIGH) + 2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          primed_q, primed_d;
  ratio_code_t   prev_q, prev_d, code_q, code_d, meas_cls;
  logic          lock_q, lock_d;

  // Saturating tick count; the frame tick's own cycle is included.
  always_comb begin
    if (mclk_tick && (cnt_q != CNT_MAX)) cnt_inc = cnt_q + 1'b1;
    else                                 cnt_inc = cnt_q;
    if      (cnt_inc == CW'(RATIO_LOW))  meas_cls = RAT_LOW;
    else if (cnt_inc == CW'(RATIO_MID))  meas_cls = RAT_MID;
    else if (cnt_inc == CW'(RATIO_HIGH)) meas_cls = RAT_HIGH;
    else                                 meas_cls = RAT_NONE;
  end

  always_comb begin
    cnt_d    = cnt_inc;
    primed_d = primed_q;
    prev_d   = prev_q;
    lock_d   = lock_q;
    code_d   = code_q;
    if (!mclk_ok) begin
      cnt_d    = '0;
      primed_d = 1'b0;
      prev_d   = RAT_NONE;
      lock_d   = 1'b0;
      code_d   = RAT_NONE;
    end else if (frame_tick) begin
      cnt_d    = '0;
      primed_d = 1'b1;
      if (primed_q) begin
        prev_d = meas_cls;
        if ((meas_cls != RAT_NONE) && (meas_cls == prev_q)) begin
          lock_d = 1'b1;
          code_d = meas_cls;
        end else begin
          lock_d = 1'b0;
          code_d = RAT_NONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      prev_q   <= RAT_NONE;
      lock_q   <= 1'b0;
      code_q   <= RAT_NONE;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      prev_q   <= prev_d;
      lock_q   <= lock_d;
      code_q   <= code_d;
    end
  end

  assign lock = lock_q;
  assign code = code_q;
endmodule

// File: rtl/cis_seq_fsm.sv
module cis_seq_fsm
  import conv_init_pkg::*;
#(
  parameter int REF_FRAMES    = 32,
  parameter int SETTLE_FRAMES = 28672,
  parameter int CAL_FRAMES    = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       mclk_ok,
  input  logic       frame_tick,
  input  logic       hp_defeat,
  output seq_state_t state
);
  localparam int MAX_A = (REF_FRAMES > CAL_FRAMES) ? REF_FRAMES : CAL_FRAMES;
  localparam int MAX_F = (MAX_A > SETTLE_FRAMES) ? MAX_A : SETTLE_FRAMES;
  localparam int FW    = $clog2(MAX_F + 1);

  seq_state_t    st_q, st_d, st_after;
  logic [FW-1:0] fcnt_q, fcnt_d, lim;
  logic          fcnt_en;

  always_comb begin
    case (st_q)
      ST_REF:    begin lim = FW'(REF_FRAMES - 1);    st_after = hp_defeat ? ST_ISO : ST_SETTLE; end
      ST_SETTLE: begin lim = FW'(SETTLE_FRAMES - 1); st_after = ST_RDY; end
      ST_ISO:    begin lim = '0;                     st_after = ST_CAL; end
      ST_CAL:    begin lim = FW'(CAL_FRAMES - 1);    st_after = ST_RDY; end
      default:   begin lim = '0;                     st_after = st_q;   end
    endcase
  end

  always_comb begin
    st_d    = st_q;
    fcnt_d  = fcnt_q;
    fcnt_en = 1'b0;
    if (!mclk_ok && (st_q != ST_PDN)) begin
      st_d    = ST_PDN;
      fcnt_d  = '0;
      fcnt_en = 1'b1;
    end else begin
      case (st_q)
        ST_PDN: if (go) begin
          st_d    = ST_REF;
          fcnt_d  = '0;
          fcnt_en = 1'b1;
        end
        ST_REF, ST_SETTLE, ST_ISO, ST_CAL: if (frame_tick) begin
          fcnt_en = 1'b1;
          if (fcnt_q == lim) begin
            st_d   = st_after;
            fcnt_d = '0;
          end else begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PDN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fcnt_q <= '0;
    else if (fcnt_en) fcnt_q <= fcnt_d;
  end

  assign state = st_q;
endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
  import conv_init_pkg::*;
#(
  parameter int REF_FRAMES    = 32,
  parameter int SETTLE_FRAMES = 28672,
  parameter int CAL_FRAMES    = 4096,
  parameter int TIMEOUT       = 64,
  parameter int RATIO_LOW     = 256,
  parameter int RATIO_MID     = 384,
  parameter int RATIO_HIGH    = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_mode,
  input  logic       hp_defeat,
  input  logic       mclk_tick,
  input  logic       frame_tick,
  output logic       pdn,
  output logic       ref_en,
  output logic       in_disc,
  output logic       cal_short,
  output logic       ready,
  output logic       oclk_en,
  output logic [1:0] ratio_code
);
  logic        rst_meta, rst_sync;
  logic        mclk_ok, lock, go;
  ratio_code_t code;
  seq_state_t  state;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cis_mclk_watch #(.TIMEOUT(TIMEOUT)) u_watch (
    .clk(clk), .rst_n(rst_sync), .mclk_tick(mclk_tick), .mclk_ok(mclk_ok)
  );

  cis_ratio_meter #(
    .RATIO_LOW(RATIO_LOW), .RATIO_MID(RATIO_MID), .RATIO_HIGH(RATIO_HIGH)
  ) u_meter (
    .clk(clk), .rst_n(rst_sync), .mclk_ok(mclk_ok), .mclk_tick(mclk_tick),
    .frame_tick(frame_tick), .lock(lock), .code(code)
  );

  assign go = mclk_ok && (master_mode || lock);

  cis_seq_fsm #(
    .REF_FRAMES(REF_FRAMES), .SETTLE_FRAMES(SETTLE_FRAMES), .CAL_FRAMES(CAL_FRAMES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync), .go(go), .mclk_ok(mclk_ok),
    .frame_tick(frame_tick), .hp_defeat(hp_defeat), .state(state)
  );

  assign pdn        = (state == ST_PDN);
  assign ref_en     = !pdn;
  assign in_disc    = (state == ST_ISO) || (state == ST_CAL);
  assign cal_short  = (state == ST_CAL);
  assign ready      = (state == ST_RDY);
  assign oclk_en    = master_mode && !pdn;
  assign ratio_code = code;
endmodule

// File: rtl/conv_init_seq_chk.sv
module conv_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master_mode,
  input logic       pdn,
  input logic       ref_en,
  input logic       in_disc,
  input logic       cal_short,
  input logic       ready,
  input logic [1:0] ratio_code
);
  assert_ready_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ref_en && !in_disc && !cal_short && !pdn));

  assert_pdn_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |-> (!ref_en && !in_disc && !cal_short && !ready));

  assert_iso_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_short) |-> $past(in_disc));

  assert_slave_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pdn) && !master_mode) |-> (ratio_code != 2'd0));

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (ready || pdn));
endmodule

bind conv_init_seq conv_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .pdn(pdn),
  .ref_en(ref_en), .in_disc(in_disc), .cal_short(cal_short),
  .ready(ready), .ratio_code(ratio_code)
);

// File: tb/conv_init_seq_test.sv
`timescale 1ns/1ps
module conv_init_seq_test;
  localparam int REF_F = 4;
  localparam int SET_F = 10;
  localparam int CAL_F = 6;
  localparam int TO    = 40;

  logic clk = 1'b0;
  logic rst_n, master_mode, hp_defeat, mclk_tick, frame_tick;
  logic pdn, ref_en, in_disc, cal_short, ready, oclk_en;
  logic [1:0] ratio_code;

  int n_chk = 0, n_fail = 0;
  int n_pdn, n_refset, n_iso, n_cal;
  bit mclk_run = 0, frame_run = 0, alt = 0;
  int cur_r = 256, tickcnt = 0;

  conv_init_seq #(
    .REF_FRAMES(REF_F), .SETTLE_FRAMES(SET_F), .CAL_FRAMES(CAL_F), .TIMEOUT(TO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .hp_defeat(hp_defeat),
    .mclk_tick(mclk_tick), .frame_tick(frame_tick), .pdn(pdn), .ref_en(ref_en),
    .in_disc(in_disc), .cal_short(cal_short), .ready(ready), .oclk_en(oclk_en),
    .ratio_code(ratio_code)
  );

  always #10 clk = ~clk;

  // Tick generator: one master tick per cycle, frame tick on every cur_r-th.
  initial begin
    mclk_tick = 1'b0;
    frame_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      mclk_tick = mclk_run;
      frame_tick = 1'b0;
      if (mclk_run) begin
        tickcnt++;
        if (frame_run && tickcnt >= cur_r) begin
          frame_tick = 1'b1;
          tickcnt = 0;
          if (alt) cur_r = (cur_r == 256) ? 384 : 256;
        end
      end
    end
  end

  // Tally frame ticks by the phase shown at the outputs.
  always @(negedge clk) begin
    if (frame_tick) begin
      if (pdn)            n_pdn++;
      else if (ready)     ;
      else if (cal_short) n_cal++;
      else if (in_disc)   n_iso++;
      else                n_refset++;
    end
  end

  function automatic int code_of(int r);
    return (r == 256) ? 1 : (r == 384) ? 2 : (r == 512) ? 3 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_tally();
    n_pdn = 0; n_refset = 0; n_iso = 0; n_cal = 0;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(bit mm, bit hp);
    mclk_run = 0; frame_run = 0; alt = 0; tickcnt = 0;
    master_mode = mm; hp_defeat = hp;
    rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
    clr_tally();
  endtask

  task automatic wait_sig(ref logic s, input logic v, input int lim, input string req);
    int k;
    k = 0;
    while (s !== v && k < lim) begin @(negedge clk); k++; end
    check(s === v, req, s, v);
  endtask

  task automatic run_slave(int r, bit hp, bit flip_hp);
    do_reset(1'b0, hp);
    cur_r = r;
    mclk_run = 1;
    cycles(20);
    clr_tally();
    frame_run = 1;
    wait_sig(pdn, 1'b0, 8 * r, "R3 pdn exit");
    check(n_pdn == 3, "R4 frames before exit", n_pdn, 3);
    check(ratio_code == 2'(code_of(r)), "R3 ratio code", ratio_code, code_of(r));
    check(oclk_en == 1'b0, "R10 slave oclk", oclk_en, 0);
    if (flip_hp) begin
      while (n_refset <= REF_F) @(negedge clk);
      hp_defeat = ~hp_defeat;
    end
    wait_sig(ready, 1'b1, 40 * r, "R6 ready");
    if (hp && !flip_hp) begin
      check(n_refset == REF_F, "R5 reference wait", n_refset, REF_F);
      check(n_iso == 1, "R7 isolate frame", n_iso, 1);
      check(n_cal == CAL_F, "R7 calibrate frames", n_cal, CAL_F);
    end else begin
      check(n_refset == REF_F + SET_F, "R6 settle frames", n_refset, REF_F + SET_F);
      check(n_iso + n_cal == 0, "R11 no calibration", n_iso + n_cal, 0);
    end
    check(!in_disc && !cal_short && ref_en, "R8 ready clean", {in_disc, cal_short, ref_en}, 1);
  endtask

  initial begin
    #(20ns * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    master_mode = 1'b0; hp_defeat = 1'b0;
    rst_n = 1'b0;
    cycles(3);
    check(pdn == 1'b1, "R1 pdn in reset", pdn, 1);
    check({ref_en, in_disc, cal_short, ready, oclk_en} == 5'b0, "R1 outputs low",
          {ref_en, in_disc, cal_short, ready, oclk_en}, 0);
    check(ratio_code == 2'd0, "R1 ratio", ratio_code, 0);

    // R2, R5, R10: master mode leaves power-down on master clock alone
    do_reset(1'b1, 1'b0);
    cycles(30);
    check(pdn == 1'b1, "R1 idle without clocks", pdn, 1);
    mclk_run = 1;
    cycles(6);
    check(pdn == 1'b0, "R2 master exit", pdn, 0);
    check(ref_en == 1'b1, "R5 ref enabled", ref_en, 1);
    check(oclk_en == 1'b1, "R10 master oclk", oclk_en, 1);
    cur_r = 256;
    frame_run = 1;
    wait_sig(ready, 1'b1, 20000, "R6 master ready");
    check(n_refset == REF_F + SET_F, "R6 master settle frames", n_refset, REF_F + SET_F);

    // R9: short gap has no effect, long gap returns to power-down
    frame_run = 0;
    mclk_run = 0;
    cycles(TO - 4);
    mclk_run = 1;
    cycles(4);
    check(ready == 1'b1, "R9 short gap ignored", ready, 1);
    mclk_run = 0;
    cycles(TO - 4);
    check(pdn == 1'b0, "R9 before timeout", pdn, 0);
    cycles(8);
    check(pdn == 1'b1, "R9 after timeout", pdn, 1);
    check({ref_en, ready, oclk_en} == 3'b0 && ratio_code == 2'd0, "R9 outputs cleared",
          {ref_en, ready, oclk_en, ratio_code}, 0);

    // R3: unsupported ratio never locks
    do_reset(1'b0, 1'b0);
    cur_r = 300; mclk_run = 1; frame_run = 1;
    cycles(300 * 7);
    check(pdn == 1'b1, "R3 bad ratio stays down", pdn, 1);
    check(ratio_code == 2'd0, "R3 bad ratio code", ratio_code, 0);

    // R3: alternating supported ratios never lock
    do_reset(1'b0, 1'b0);
    cur_r = 256; alt = 1; mclk_run = 1; frame_run = 1;
    cycles(320 * 8);
    check(pdn == 1'b1, "R3 alternating stays down", pdn, 1);
    alt = 0;

    // R7: calibration path; R11: hp flip during settling ignored
    run_slave(384, 1'b1, 1'b0);
    run_slave(512, 1'b0, 1'b1);

    // Constrained random runs
    void'($urandom(32'd1234));
    for (int it = 0; it < 4; it++) begin
      int rsel;
      bit hp, mm;
      rsel = 256 + 128 * int'($urandom_range(0, 2));
      hp = 1'($urandom_range(0, 1));
      mm = 1'($urandom_range(0, 1));
      if (mm) begin
        do_reset(1'b1, hp);
        cur_r = rsel; mclk_run = 1; frame_run = 1;
        wait_sig(ready, 1'b1, 40 * rsel, "R2 random master ready");
        check(oclk_en == 1'b1, "R10 random master oclk", oclk_en, 1);
        if (hp) check(n_cal == CAL_F && n_iso == 1, "R7 random cal", n_cal, CAL_F);
        else    check(n_refset == REF_F + SET_F, "R6 random settle", n_refset, REF_F + SET_F);
      end else begin
        run_slave(rsel, hp, 1'b0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule